// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block watches the running time of a real-time clock and raises a sticky alarm flag when the time matches a programmed alarm. Six alarm bytes hold the target values for seconds, minutes, hours, day-of-month, month and weekday. In each alarm byte, bit 7 says whether that field takes part in the comparison. The year and sub-second counts are not compared. Software can enable one field, any combination of fields, or all six.

The timekeeping logic supplies the six current time bytes and a one-cycle advance strobe. The comparison is made only on the strobe cycle. If every enabled field matches, the alarm flag is set on the next clock edge. It then stays set until software clears it, either by writing zero to it or by reading the status byte while the auto-clear control bit is set. A simple single-cycle register port gives access to the alarm bytes, the status byte and the control byte. An active-low interrupt level follows the flag.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the alarm flag is 0, `alarm_irq_n` is 1, every alarm byte reads 0x00 and the control byte reads 0x00.
- R2: Alarm bytes live at addresses 0x0C (seconds), 0x0D (minutes), 0x0E (hours), 0x0F (day-of-month), 0x10 (month) and 0x11 (weekday). A write stores all 8 bits. A read asserted in one cycle presents the stored byte on `reg_rdata` from the next clock edge. In `time_now`, field k occupies bits [8k+7:8k], using the same field order as the addresses.
- R3: Bit 7 of an alarm byte enables its field. A match requires bits 6:0 of each enabled alarm byte to equal bits 6:0 of the corresponding time byte. Bit 7 of the time byte and all disabled fields are ignored.
- R4: The comparison happens only in a cycle where `time_tick` is 1. On a match, the flag reads 1 after the next clock edge. A matching time without the strobe leaves the flag unchanged.
- R5: When no enable bit is set, the strobe never sets the flag, whatever the time values are.
- R6: Once set, the flag stays 1 across later strobes that do not match.
- R7: Writing to the status byte at 0x0A with bit 0 equal to 0 clears the flag. Writing bit 0 equal to 1 neither sets nor clears it.
- R8: Bit 7 of the control byte at 0x0B is the auto-clear enable; the other control bits read 0. A read of 0x0A returns the flag in bit 0, with the other bits 0. If auto-clear is 1, the same read clears the flag. If auto-clear is 0, the read leaves the flag unchanged.
- R9: A match in the same cycle as a clearing write or an auto-clearing status read leaves the flag set.
- R10: `alarm_irq_n` is 0 exactly while the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| time_now | input | 48 | Current time bytes, field k at bits [8k+7:8k] |
| time_tick | input | 1 | One-cycle strobe when the time advances |
| alm_flag | output | 1 | Sticky alarm flag |
| alarm_irq_n | output | 1 | Active-low alarm interrupt level |

## Verification
The bench uses the default build: six 8-bit fields, with the alarm bank at 0x0C and the status and control bytes at 0x0A and 0x0B. With six fields there are only 64 enable subsets, so the bench sweeps all of them. For each subset it applies a fully matching time and six single-field mismatches. The expected flag is computed from the mask arithmetically. Directed sequences then cover the corner cases: strobe gating, stickiness, and the write-clear and read-clear paths with their same-cycle conflicts against a match.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants for the RTC alarm comparator.
// Assumes byte-wide registers and an 8-bit register address space.
package rtc_alarm_pkg;
    localparam int REG_W       = 8;
    localparam int ADDR_W      = 8;
    localparam int FIELD_COUNT = 6;
    localparam int BANK_BASE   = 'h0C;
    localparam int STAT_ADDR   = 'h0A;
    localparam int CTRL_ADDR   = 'h0B;
    localparam int FLAG_BIT    = 0;
    localparam int AUTOCLR_BIT = 7;
endpackage

// File: rtl/alarm_bank.sv
// Storage for the alarm bytes, one register per compared field.
// Field k sits at address BASE+k. The MSB of each byte is its enable.
// Assumes one write per cycle; no read port here (the top muxes it).
module alarm_bank #(
    parameter int NF   = 6,
    parameter int DW   = 8,
    parameter int AW   = 8,
    parameter int BASE = 'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [NF*DW-1:0] bytes_q,
    output logic [NF-1:0]    en_mask
);
    for (genvar k = 0; k < NF; k++) begin : g_field
        logic [DW-1:0] val_q;
        logic          hit;

        assign hit = wr_en && (addr == AW'(BASE + k));

        // Capture the alarm byte when its own address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)   val_q <= '0;
            else if (hit) val_q <= wdata;
        end

        assign bytes_q[k*DW +: DW] = val_q;
        assign en_mask[k]          = val_q[DW-1];
    end
endmodule

// File: rtl/match_eval.sv
// Compares each enabled alarm field against the matching time field.
// Only bits below the MSB take part, and no BCD range check is made.
// Assumes the time bytes are stable in the strobe cycle.
module match_eval #(
    parameter int NF = 6,
    parameter int DW = 8
) (
    input  logic [NF*DW-1:0] alarm_bytes,
    input  logic [NF-1:0]    en_mask,
    input  logic [NF*DW-1:0] time_bytes,
    input  logic             tick,
    output logic             match_hit
);
    localparam int CW = DW - 1;

    logic [NF-1:0] field_ok;

    for (genvar k = 0; k < NF; k++) begin : g_cmp
        logic same;
        assign same        = alarm_bytes[k*DW +: CW] == time_bytes[k*DW +: CW];
        assign field_ok[k] = !en_mask[k] || same;
    end

    // A hit needs the strobe, at least one enabled field and no mismatch.
    always_comb begin
        match_hit = tick && (|en_mask) && (&field_ok);
    end
endmodule

// File: rtl/status_ctrl.sv
// Holds the sticky alarm flag and the auto-clear control bit.
// A set from a match takes priority over both clearing paths.
// Assumes a status read and a write do not target this block in one cycle.
module status_ctrl #(
    parameter int DW       = 8,
    parameter int AW       = 8,
    parameter int STAT_A   = 'h0A,
    parameter int CTRL_A   = 'h0B,
    parameter int FLAG_B   = 0,
    parameter int AUTOCL_B = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          match_hit,
    output logic          flag_q,
    output logic          autoclr_q
);
    logic stat_sel;
    logic ctrl_sel;
    logic wr_clear;
    logic rd_clear;

    assign stat_sel = addr == AW'(STAT_A);
    assign ctrl_sel = addr == AW'(CTRL_A);
    assign wr_clear = wr_en && stat_sel && !wdata[FLAG_B];
    assign rd_clear = rd_en && stat_sel && autoclr_q;

    // Sticky flag: set by a match, otherwise cleared by write or read.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (match_hit)            flag_q <= 1'b1;
        else if (wr_clear || rd_clear) flag_q <= 1'b0;
    end

    // Auto-clear enable taken from the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                  autoclr_q <= 1'b0;
        else if (wr_en && ctrl_sel)  autoclr_q <= wdata[AUTOCL_B];
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Top level of the RTC alarm comparator: alarm bank, field comparator,
// status/control and a registered read mux.
// Assumes the time source gives a one-cycle strobe per advance.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int NF       = FIELD_COUNT,
    parameter int DW       = REG_W,
    parameter int AW       = ADDR_W,
    parameter int BASE     = BANK_BASE,
    parameter int STAT_A   = STAT_ADDR,
    parameter int CTRL_A   = CTRL_ADDR,
    parameter int FLAG_B   = FLAG_BIT,
    parameter int AUTOCL_B = AUTOCLR_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NF*DW-1:0] time_now,
    input  logic             time_tick,
    output logic             alm_flag,
    output logic             alarm_irq_n
);
    logic [NF*DW-1:0] alarm_bytes;
    logic [NF-1:0]    en_mask;
    logic             match_hit;
    logic             arst_en;
    logic [DW-1:0]    rd_mux;

    alarm_bank #(.NF(NF), .DW(DW), .AW(AW), .BASE(BASE)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .bytes_q (alarm_bytes),
        .en_mask (en_mask)
    );

    match_eval #(.NF(NF), .DW(DW)) u_eval (
        .alarm_bytes (alarm_bytes),
        .en_mask     (en_mask),
        .time_bytes  (time_now),
        .tick        (time_tick),
        .match_hit   (match_hit)
    );

    status_ctrl #(
        .DW(DW), .AW(AW), .STAT_A(STAT_A), .CTRL_A(CTRL_A),
        .FLAG_B(FLAG_B), .AUTOCL_B(AUTOCL_B)
    ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .match_hit (match_hit),
        .flag_q    (alm_flag),
        .autoclr_q (arst_en)
    );

    // Select the byte addressed by a read; unmapped addresses give zero.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NF; k++) begin
            if (reg_addr == AW'(BASE + k)) rd_mux = alarm_bytes[k*DW +: DW];
        end
        if (reg_addr == AW'(STAT_A)) rd_mux[FLAG_B]   = alm_flag;
        if (reg_addr == AW'(CTRL_A)) rd_mux[AUTOCL_B] = arst_en;
    end

    // Register read data so it appears one edge after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assign alarm_irq_n = !alm_flag;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Property checker for rtc_alarm_match, attached with bind below.
// Assumes the default parameter set of the top module.
module rtc_alarm_match_chk #(
    parameter int NF     = 6,
    parameter int DW     = 8,
    parameter int AW     = 8,
    parameter int STAT_A = 'h0A,
    parameter int FLAG_B = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          time_tick,
    input logic          alm_flag,
    input logic          match_hit,
    input logic [NF-1:0] en_mask,
    input logic          arst_en
);
    logic clr_wr;
    logic clr_rd;

    assign clr_wr = reg_wr && (reg_addr == AW'(STAT_A)) && !reg_wdata[FLAG_B];
    assign clr_rd = reg_rd && (reg_addr == AW'(STAT_A)) && arst_en;

    // R4: no comparison outside the strobe cycle
    p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !time_tick |-> !match_hit);
    // R4: a hit sets the flag on the next edge
    p_hit_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> alm_flag);
    // R5: no enabled field means no hit
    p_no_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |-> !match_hit);
    // R6: the flag holds without a clearing access
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag && !clr_wr && !clr_rd) |=> alm_flag);
    // R7: only a hit can raise the flag
    p_only_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_flag && !match_hit) |=> !alm_flag);
    // R7: a clearing write drops the flag
    p_write_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !match_hit) |=> !alm_flag);
    // R8: an auto-clearing status read drops the flag
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !match_hit) |=> !alm_flag);
    // R9: a hit beats a simultaneous clear
    p_hit_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && (clr_wr || clr_rd)) |=> alm_flag);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .time_tick (time_tick),
    .alm_flag  (alm_flag),
    .match_hit (match_hit),
    .en_mask   (en_mask),
    .arst_en   (arst_en)
);

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;
    localparam int NF = 6;
    localparam int DW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [7:0]       reg_addr = '0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic [NF*DW-1:0] time_now = '0;
    logic             time_tick = 1'b0;
    logic             alm_flag;
    logic             alarm_irq_n;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rtc_alarm_match uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .time_now(time_now), .time_tick(time_tick),
        .alm_flag(alm_flag), .alarm_irq_n(alarm_irq_n)
    );

    function automatic logic [6:0] base_val(input int k);
        return 7'((k * 11 + 3) % 100);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic do_tick(input logic [NF*DW-1:0] t);
        time_now = t; time_tick = 1'b1;
        @(negedge clk);
        time_tick = 1'b0;
    endtask

    function automatic logic [NF*DW-1:0] full_match(input logic [NF-1:0] top_bits);
        logic [NF*DW-1:0] t;
        for (int k = 0; k < NF; k++) t[k*DW +: DW] = {top_bits[k], base_val(k)};
        return t;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [NF*DW-1:0] t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 flag", alm_flag, 0);
        chk("R1 irq_n", alarm_irq_n, 1);
        for (int k = 0; k < NF; k++) begin
            do_read(8'(8'h0C + k), rd);
            chk("R1 alarm byte", rd, 0);
        end
        do_read(8'h0B, rd);
        chk("R1 control", rd, 0);

        // R2: write and read back every alarm byte
        for (int k = 0; k < NF; k++) do_write(8'(8'h0C + k), 8'(8'hA1 + k * 8'h13));
        for (int k = 0; k < NF; k++) begin
            do_read(8'(8'h0C + k), rd);
            chk("R2 readback", rd, 8'(8'hA1 + k * 8'h13));
        end

        // R3, R5: all 64 enable subsets, full match and each single mismatch
        for (int m = 0; m < 64; m++) begin
            for (int k = 0; k < NF; k++) do_write(8'(8'h0C + k), {m[k], base_val(k)});
            for (int p = 0; p <= NF; p++) begin
                logic exp;
                t = full_match(NF'(m * 37));
                if (p > 0) t[(p-1)*DW +: 7] = t[(p-1)*DW +: 7] ^ 7'h01;
                exp = (m != 0) && !(p > 0 && m[p-1]);
                do_tick(t);
                chk(m == 0 ? "R5 no enable" : "R3 field match", alm_flag, exp);
                if (alm_flag) do_write(8'h0A, 8'h00);
            end
        end

        // R4: matching time without strobe does nothing
        for (int k = 0; k < NF; k++) do_write(8'(8'h0C + k), {1'b1, base_val(k)});
        time_now = full_match('0);
        repeat (3) @(negedge clk);
        chk("R4 no strobe", alm_flag, 0);
        do_tick(full_match('0));
        chk("R4 strobe sets", alm_flag, 1);
        chk("R10 irq low", alarm_irq_n, 0);

        // R6: mismatching strobes keep the flag
        t = full_match('0); t[7:0] = 8'h7F;
        do_tick(t); do_tick(t);
        chk("R6 sticky", alm_flag, 1);

        // R7: writing 1 keeps it, writing 0 clears, writing 1 cannot set
        do_write(8'h0A, 8'hFF);
        chk("R7 write one keeps", alm_flag, 1);
        do_write(8'h0A, 8'hFE);
        chk("R7 write zero clears", alm_flag, 0);
        chk("R10 irq high", alarm_irq_n, 1);
        do_write(8'h0A, 8'h01);
        chk("R7 write one no set", alm_flag, 0);

        // R8: read without auto-clear, then with it
        do_tick(full_match('0));
        do_read(8'h0A, rd);
        chk("R8 status read", rd, 8'h01);
        chk("R8 no autoclr keeps", alm_flag, 1);
        do_write(8'h0B, 8'hFF);
        do_read(8'h0B, rd);
        chk("R8 control readback", rd, 8'h80);
        do_read(8'h0A, rd);
        chk("R8 read shows flag", rd, 8'h01);
        chk("R8 autoclr clears", alm_flag, 0);
        do_read(8'h0A, rd);
        chk("R8 status after clear", rd, 8'h00);

        // R9: match together with auto-clearing read
        time_now = full_match('0); time_tick = 1'b1;
        reg_rd = 1'b1; reg_addr = 8'h0A;
        @(negedge clk);
        time_tick = 1'b0; reg_rd = 1'b0;
        chk("R9 read vs match", alm_flag, 1);
        // R9: match together with clearing write
        time_tick = 1'b1; reg_wr = 1'b1; reg_addr = 8'h0A; reg_wdata = 8'h00;
        @(negedge clk);
        time_tick = 1'b0; reg_wr = 1'b0;
        chk("R9 write vs match", alm_flag, 1);
        do_write(8'h0A, 8'h00);
        chk("R7 final clear", alm_flag, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule